// File: doc/BRIEF.md
# Odd-Down Even-Up Sequence Counter

This block is a small free-running counter whose output follows a fixed cycle that is not binary order. Starting from the top value it walks down through the odd codes, crosses to zero, then climbs through the even codes. With the default 3-bit width that gives 7, 5, 3, 1, 0, 2, 4, 6, after which it wraps to 7 again. The count advances on the falling edge of the clock only. An asynchronous active-high reset forces the output to zero at once, whatever the clock is doing.

Each state bit is a negative-edge storage element built from two level-sensitive latches in master-slave order. The master is open while the clock is high and the slave is open while it is low, so a new value reaches the output only at the high-to-low transition. Every latch picks between its held value and new data with a 2:1 multiplexer made of NAND gates. Reset acts on both latches of every bit. A combinational next-state stage computes each bit from all current bits.

The interface has only a clock, a reset and the count. There is no enable, no load and no direction control.

Top module: `zigzag_counter`

## Requirements
- R1: With reset low, each falling clock edge moves count_o (unsigned binary) along the cycle 0→2→4→6→7→5→3→1→0, and this order repeats without end.
- R2: count_o does not change on a rising clock edge, and it does not change while the clock holds a level.
- R3: Raising rst_i sets count_o to 0 within the same clock phase, with no clock edge needed, whether the clock is high or low at that moment.
- R4: After rst_i falls, count_o stays 0 through any rising edge and until the next falling edge, and that falling edge sets it to 2.
- R5: While rst_i stays high, count_o stays 0 across any number of rising and falling clock edges.
- R6: Both turning points of the cycle hold: 1 is followed by 0, and 6 (the largest even code) is followed by 7 (the largest code).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the count advances on its falling edge |
| rst_i | input | 1 | Asynchronous active-high reset; forces the count to 0 |
| count_o | output | W (3) | Current value of the sequence |

## Verification
The hardest cases to reach from the ports are the reset edges that fall inside a clock phase. These are an assertion while the clock is high or low, which must clear the output with no edge at all, and a release partway through a phase, after which a rising edge must not move the count. The bench drives rst_i at fixed offsets of about 1 ns into a chosen phase. It samples the output a fraction of a nanosecond later, before the next edge, then again after the next rising edge and after the first falling edge. Because the cycle runs twice from a known start, the two turning points are each crossed twice.

// File: rtl/zzc_pkg.sv
package zzc_pkg;

    // Default number of state bits of the counter.
    localparam int unsigned ZZC_WIDTH = 3;

endpackage

// File: rtl/zzc_nand2.sv
module zzc_nand2 (
    input  logic a_i,
    input  logic b_i,
    output logic y_o
);

    assign y_o = ~(a_i & b_i);

endmodule

// File: rtl/zzc_nand_mux2.sv
// 2:1 selector built only from two-input NAND gates.
// sel_i = 1 passes pass_i, sel_i = 0 passes hold_i.
module zzc_nand_mux2 (
    input  logic sel_i,
    input  logic hold_i,
    input  logic pass_i,
    output logic y_o
);

    logic sel_n;
    logic hold_term_n;
    logic pass_term_n;

    zzc_nand2 u_sel_inv (
        .a_i (sel_i),
        .b_i (sel_i),
        .y_o (sel_n)
    );

    zzc_nand2 u_hold_term (
        .a_i (hold_i),
        .b_i (sel_n),
        .y_o (hold_term_n)
    );

    zzc_nand2 u_pass_term (
        .a_i (pass_i),
        .b_i (sel_i),
        .y_o (pass_term_n)
    );

    zzc_nand2 u_merge (
        .a_i (hold_term_n),
        .b_i (pass_term_n),
        .y_o (y_o)
    );

endmodule

// File: rtl/zzc_latch.sv
// Level-sensitive latch: open while en_i is high, holding otherwise.
// The output comes from a NAND selector between the held value and
// the incoming data. Reset clears the held value and blocks the data path.
module zzc_latch (
    input  logic en_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic rst_n;
    logic data_n;
    logic data_gated;
    logic store_q;

    zzc_nand2 u_rst_inv (
        .a_i (rst_i),
        .b_i (rst_i),
        .y_o (rst_n)
    );

    zzc_nand2 u_data_gate (
        .a_i (d_i),
        .b_i (rst_n),
        .y_o (data_n)
    );

    zzc_nand2 u_data_inv (
        .a_i (data_n),
        .b_i (data_n),
        .y_o (data_gated)
    );

    // Storage node of the latch.
    always_latch begin
        if (rst_i) begin
            store_q <= 1'b0;
        end else if (en_i) begin
            store_q <= data_gated;
        end
    end

    zzc_nand_mux2 u_sel (
        .sel_i  (en_i),
        .hold_i (store_q),
        .pass_i (data_gated),
        .y_o    (q_o)
    );

endmodule

// File: rtl/zzc_negedge_ff.sv
// Falling-edge storage bit made of a master latch (open on clock high)
// followed by a slave latch (open on clock low).
module zzc_negedge_ff (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);

    logic clk_n;
    logic master_q;

    zzc_nand2 u_clk_inv (
        .a_i (clk_i),
        .b_i (clk_i),
        .y_o (clk_n)
    );

    zzc_latch u_master (
        .en_i  (clk_i),
        .rst_i (rst_i),
        .d_i   (d_i),
        .q_o   (master_q)
    );

    zzc_latch u_slave (
        .en_i  (clk_n),
        .rst_i (rst_i),
        .d_i   (master_q),
        .q_o   (q_o)
    );

endmodule

// File: rtl/zigzag_counter.sv
// Counter walking odd codes downward from the top, then even codes upward
// from zero, advancing on the falling clock edge.
module zigzag_counter #(
    parameter int unsigned W = zzc_pkg::ZZC_WIDTH
) (
    input  logic         clk_i,
    input  logic         rst_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] STEP     = W'(2);
    localparam logic [W-1:0] LOW_ODD  = W'(1);
    localparam logic [W-1:0] TOP_CODE = {W{1'b1}};
    localparam logic [W-1:0] TOP_EVEN = TOP_CODE - W'(1);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    // Next value: odd codes step down, even codes step up, with a
    // turn at the lowest odd code and at the highest even code.
    always_comb begin
        if (cnt_q[0]) begin
            if (cnt_q == LOW_ODD) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q - STEP;
            end
        end else begin
            if (cnt_q == TOP_EVEN) begin
                cnt_d = TOP_CODE;
            end else begin
                cnt_d = cnt_q + STEP;
            end
        end
    end

    // One falling-edge bit per state bit.
    for (genvar b = 0; b < W; b++) begin : g_bit
        zzc_negedge_ff u_ff (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .d_i   (cnt_d[b]),
            .q_o   (cnt_q[b])
        );
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/zzc_checker.sv
module zzc_checker #(
    parameter int unsigned W = 3
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic [W-1:0] count_o
);

    function automatic logic [W-1:0] exp_next(input logic [W-1:0] v);
        logic [W-1:0] top;
        top = {W{1'b1}};
        if (v == '0) begin
            exp_next = W'(2);
        end else if (v == top - W'(1)) begin
            exp_next = top;
        end else if (v[0] && v == W'(1)) begin
            exp_next = '0;
        end else if (v[0]) begin
            exp_next = v - W'(2);
        end else begin
            exp_next = v + W'(2);
        end
    endfunction

    // R1, R6: one step of the cycle per falling edge.
    assert_step_order_R1: assert property (@(negedge clk_i) disable iff (rst_i)
        1'b1 |=> count_o == exp_next($past(count_o)));

    // R2: between rising edges exactly one falling-edge step took place.
    assert_rise_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> count_o == exp_next($past(count_o)));

    // R3: reset seen at a rising edge means the count is already zero.
    assert_reset_zero_R3: assert property (@(posedge clk_i)
        rst_i |-> count_o == '0);

    // R5: reset seen at a falling edge means the count is zero.
    assert_reset_hold_R5: assert property (@(negedge clk_i)
        rst_i |-> count_o == '0);

    // R4: first falling edge after release still finds zero.
    assert_release_zero_R4: assert property (@(negedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> count_o == '0);

endmodule

bind zigzag_counter zzc_checker #(.W(W)) u_zzc_checker (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .count_o (count_o)
);

// File: tb/tb_zigzag_counter.sv
`timescale 1ns/100ps
module tb_zigzag_counter;

    logic       clk;
    logic       rst;
    logic [2:0] count;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    zigzag_counter #(.W(3)) dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .count_o (count)
    );

    initial begin
        clk = 1'b0;
        forever #2.5 clk = ~clk;
    end

    // Successor in the cycle 0,2,4,6,7,5,3,1, taken from the requirement.
    function automatic logic [2:0] succ(input logic [2:0] v);
        case (v)
            3'd0: succ = 3'd2;
            3'd2: succ = 3'd4;
            3'd4: succ = 3'd6;
            3'd6: succ = 3'd7;
            3'd7: succ = 3'd5;
            3'd5: succ = 3'd3;
            3'd3: succ = 3'd1;
            default: succ = 3'd0;
        endcase
    endfunction

    task automatic check(input logic [2:0] exp, input string tag);
        n_checks++;
        if (count !== exp) begin
            n_fail++;
            $display("FAIL %s: count=%0d expected=%0d at %0t", tag, count, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // R3 and R5: reset from time zero, held over several edges.
    task automatic t_reset_hold();
        #1 check(3'd0, "R3 reset without edge");
        repeat (3) @(negedge clk);
        #1 check(3'd0, "R5 held over falling edges");
        @(posedge clk);
        #1 check(3'd0, "R5 held over rising edge");
    endtask

    // R4: release while clock is high.
    task automatic t_release_high();
        @(posedge clk);
        #1 rst = 1'b0;
        #0.5 check(3'd0, "R4 zero after release");
        @(negedge clk);
        #1 check(3'd2, "R4 first fall gives 2");
    endtask

    // R1, R2, R6: two full cycles starting from 2.
    task automatic t_two_cycles();
        logic [2:0] cur;
        cur = 3'd2;
        for (int i = 0; i < 16; i++) begin
            @(posedge clk);
            #1 check(cur, "R2 unchanged by rising edge");
            @(negedge clk);
            #1;
            if (cur == 3'd1)      check(3'd0, "R6 1 to 0 turn");
            else if (cur == 3'd6) check(3'd7, "R6 6 to 7 wrap");
            else                  check(succ(cur), "R1 cycle order");
            cur = succ(cur);
        end
    endtask

    // R3, R5, R4: reset raised during the high phase.
    task automatic t_reset_mid_high();
        @(posedge clk);
        #1 rst = 1'b1;
        #0.3 check(3'd0, "R3 cleared in high phase");
        @(negedge clk);
        #1 check(3'd0, "R5 held over falling edge");
        @(posedge clk);
        #1.2 rst = 1'b0;
        @(negedge clk);
        #1 check(3'd2, "R4 first fall after high release");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
        end
        #1 check(3'd7, "R6 reaches top code");
    endtask

    // R3, R5, R4: reset raised and released during the low phase.
    task automatic t_reset_mid_low();
        @(negedge clk);
        #1 rst = 1'b1;
        #0.3 check(3'd0, "R3 cleared in low phase");
        @(posedge clk);
        #1 check(3'd0, "R5 held over rising edge");
        @(negedge clk);
        #1 rst = 1'b0;
        #0.5 check(3'd0, "R4 zero after low release");
        @(posedge clk);
        #1 check(3'd0, "R4 rising edge does not advance");
        @(negedge clk);
        #1 check(3'd2, "R4 first fall after low release");
    endtask

    initial begin
        rst = 1'b1;
        t_reset_hold();
        t_release_high();
        t_two_cycles();
        t_reset_mid_high();
        t_reset_mid_low();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule